// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block sits between a synchronous host and an asynchronous page-mode DRAM of 256K eight-bit words. The host presents one request at a time over a ready/valid port: a read or write, an 18-bit word address, and write data when writing. The block drives the row strobe, column strobe, write strobe and output-enable strobe, all active low. It multiplexes the address onto a shared 9-bit bus: the upper nine bits go out as the row and the lower nine bits as the column. For reads it captures the returned byte and hands it back with a single-cycle valid pulse.

A row stays open after an access. A later request to the same row costs only a column-strobe cycle, and the block enforces the short page-cycle minimum for it. A request to a different row closes the row first, then the block pays the full precharge and row-cycle minimums. The row also closes when an external refresh unit is granted the memory, or when the row has been open for a configurable length of time.

Every analog minimum is a nanosecond parameter. The block rounds each one up to whole clock cycles against the clock-period parameter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: On `dram_addr`, the row is `req_addr[17:9]` at the falling edge of `dram_ras_n`, and the column is `req_addr[8:0]` at the falling edge of `dram_cas_n`.
- R3: `dram_ras_n` stays low for at least ceil(T_RAS_NS/CLK_NS) cycles. It stays high for at least ceil(T_RP_NS/CLK_NS) cycles. Two falls of `dram_ras_n` are at least ceil(T_RC_NS/CLK_NS) cycles apart.
- R4: A request whose row equals the open row is served with no edge on `dram_ras_n`. `dram_cas_n` falls only while `dram_ras_n` is low. `dram_cas_n` stays high for at least ceil(T_CP_NS/CLK_NS) cycles and low for at least ceil(T_CAS_NS/CLK_NS) cycles. Two falls of `dram_cas_n` are at least ceil(T_PC_NS/CLK_NS) cycles apart.
- R5: Read data is captured only at a clock edge that satisfies all three access times:
  - RAS low for ceil(T_RAC_NS/CLK_NS) cycles;
  - CAS and OE low for ceil(max(T_CAC_NS,T_OAC_NS)/CLK_NS) cycles;
  - the column on the bus for ceil(T_CAA_NS/CLK_NS) cycles.

  The captured byte is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R6: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the write byte on `dram_dq_out` at least one cycle before `dram_cas_n` falls. `dram_we_n` holds its level while `dram_cas_n` is low. For a read, `dram_we_n` stays high.
- R7: A request to a row other than the open row raises `dram_ras_n`, honours the minimums of R3, and opens the new row.
- R8: While `ref_grant` is high:
  - `req_ready` is low;
  - an open row is closed once its minimum low time has been met;
  - `dram_ras_n` does not fall once it is high.
- R9: An open row with no request is closed once `dram_ras_n` has been low for ceil(MAX_OPEN_NS/CLK_NS) cycles.
- R10: Only one request is outstanding. `req_ready` is low in the cycle after a request is accepted.
- R11: `dram_cas_n` does not rise, and the column stays on the bus, until `dram_ras_n` has been low for ceil(T_AR_NS/CLK_NS) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper half |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Captured read byte |
| ref_grant | input | 1 | Refresh unit owns the memory |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Write data to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Read data from the memory |

## Verification
The bench models the memory cycle by cycle and drives a poison byte until every access minimum of R5 is met. A design that captures one cycle early therefore returns the poison byte instead of the stored one. Page hits are followed immediately by misses, and the bench counts row-strobe falls across both. A design that compares the wrong address bits, or reopens the row on a hit, changes that count or breaks the R3 precharge spacing. Addresses with an all-ones row or column, and a zero address, expose a swapped or truncated row/column split. Long idle gaps and a refresh grant over an open row show whether the row is held past its limit or whether the row strobe falls during the grant.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECH,
    ST_ACT,
    ST_COLSET,
    ST_CAS,
    ST_CASPRE,
    ST_OPEN,
    ST_CLOSE
  } fpm_state_e;

  // Whole clock cycles covering a nanosecond minimum, rounded up.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_strobe_timer.sv
// Registers one active-low strobe and measures it: cycles spent at the
// present level (including the current one) and cycles since its last fall.
module fpm_strobe_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_nxt,
  output logic             strobe_n,
  output logic [CNT_W-1:0] level_cyc,
  output logic [CNT_W-1:0] fall_cyc
);
  localparam logic [CNT_W-1:0] SAT = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  logic toggles;
  logic falls;
  assign toggles = strobe_n ^ strobe_nxt;
  assign falls   = strobe_n & ~strobe_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_n  <= 1'b1;
      level_cyc <= SAT;
      fall_cyc  <= SAT;
    end else begin
      strobe_n  <= strobe_nxt;
      level_cyc <= toggles ? {{(CNT_W-1){1'b0}}, 1'b1} : bump(level_cyc);
      fall_cyc  <= falls ? {{(CNT_W-1){1'b0}}, 1'b1} : bump(fall_cyc);
    end
  end
endmodule

// File: rtl/fpm_addr_path.sv
// Splits the word address, holds the multiplexed bus, remembers the open row
// and counts how long the column has been on the bus.
module fpm_addr_path #(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W+COL_W-1:0] src_addr,
  input  logic                   load_row,
  input  logic                   load_col,
  input  logic                   latch_open,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] bus,
  output logic                   row_hit,
  output logic [CNT_W-1:0]       col_cyc
);
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [ROW_W-1:0] src_row;
  logic [COL_W-1:0] src_col;
  logic [ROW_W-1:0] open_row;

  assign src_row = src_addr[ROW_W+COL_W-1 -: ROW_W];
  assign src_col = src_addr[COL_W-1:0];
  assign row_hit = (src_row == open_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus      <= '0;
      open_row <= '0;
      col_cyc  <= '0;
    end else begin
      if (load_row)      bus <= BUS_W'(src_row);
      else if (load_col) bus <= BUS_W'(src_col);
      if (latch_open)    open_row <= src_row;
      if (load_col)      col_cyc <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (load_row) col_cyc <= '0;
      else if (col_cyc != SAT) col_cyc <= col_cyc + 1'b1;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 8,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 50,
  parameter int T_RC_NS     = 120,
  parameter int T_PC_NS     = 40,
  parameter int T_CP_NS     = 10,
  parameter int T_CAS_NS    = 15,
  parameter int T_RCD_NS    = 20,
  parameter int T_RAH_NS    = 10,
  parameter int T_AR_NS     = 45,
  parameter int T_RAC_NS    = 60,
  parameter int T_CAA_NS    = 30,
  parameter int T_CAC_NS    = 15,
  parameter int T_OAC_NS    = 15,
  parameter int MAX_OPEN_NS = 70000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   ref_grant,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int OPEN_CYC = ns_to_cyc(MAX_OPEN_NS, CLK_NS);
  localparam int CNT_W    = $clog2(OPEN_CYC + 64);

  localparam logic [CNT_W-1:0] C_RAS  = CNT_W'(ns_to_cyc(T_RAS_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_RP   = CNT_W'(ns_to_cyc(T_RP_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_RC   = CNT_W'(ns_to_cyc(T_RC_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_PC   = CNT_W'(ns_to_cyc(T_PC_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_CP   = CNT_W'(ns_to_cyc(T_CP_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_CAS  = CNT_W'(ns_to_cyc(T_CAS_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_RCD  = CNT_W'(ns_to_cyc(T_RCD_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_RAH  = CNT_W'(max2(1, ns_to_cyc(T_RAH_NS, CLK_NS)));
  localparam logic [CNT_W-1:0] C_AR   = CNT_W'(ns_to_cyc(T_AR_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_RAC  = CNT_W'(ns_to_cyc(T_RAC_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_CAA  = CNT_W'(ns_to_cyc(T_CAA_NS, CLK_NS));
  localparam logic [CNT_W-1:0] C_RDCS = CNT_W'(ns_to_cyc(max2(T_CAC_NS, T_OAC_NS), CLK_NS));
  localparam logic [CNT_W-1:0] C_OPEN = CNT_W'(OPEN_CYC);

  fpm_state_e state, state_nxt;

  logic             ras_nxt, cas_nxt, ras_n, cas_n;
  logic [CNT_W-1:0] ras_lvl, ras_fall, cas_lvl, cas_fall, col_cyc;

  logic              pend_valid, pend_write;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;

  // Named internal events, visible to the assertions below.
  logic              req_fire, row_hit, act_ok, cas_ok, xfer_done, open_expired;
  logic              rd_capture, ras_fall_evt, ras_rise_evt, cas_fall_evt, cas_rise_evt;
  logic              enter_prech, enter_colset;
  logic [ADDR_W-1:0] src_addr;
  logic              src_write;
  logic [DATA_W-1:0] src_wdata;

  fpm_strobe_timer #(.CNT_W(CNT_W)) u_ras_tmr (
    .clk(clk), .rst_n(rst_n), .strobe_nxt(ras_nxt),
    .strobe_n(ras_n), .level_cyc(ras_lvl), .fall_cyc(ras_fall)
  );

  fpm_strobe_timer #(.CNT_W(CNT_W)) u_cas_tmr (
    .clk(clk), .rst_n(rst_n), .strobe_nxt(cas_nxt),
    .strobe_n(cas_n), .level_cyc(cas_lvl), .fall_cyc(cas_fall)
  );

  fpm_addr_path #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .src_addr(src_addr),
    .load_row(enter_prech), .load_col(enter_colset), .latch_open(ras_fall_evt),
    .bus(dram_addr), .row_hit(row_hit), .col_cyc(col_cyc)
  );

  assign open_expired = (ras_lvl >= C_OPEN);
  assign req_ready    = !ref_grant &&
                        (state == ST_IDLE || (state == ST_OPEN && !open_expired));
  assign req_fire     = req_valid && req_ready;

  assign src_addr  = req_fire ? req_addr  : pend_addr;
  assign src_write = req_fire ? req_write : pend_write;
  assign src_wdata = req_fire ? req_wdata : pend_wdata;

  assign act_ok    = !ref_grant && (ras_lvl >= C_RP) && (ras_fall >= C_RC);
  assign cas_ok    = (ras_lvl >= C_RCD) && (cas_lvl >= C_CP) && (cas_fall >= C_PC);
  assign xfer_done = (cas_lvl >= C_CAS) && (ras_lvl >= C_AR) &&
                     (pend_write || ((cas_lvl >= C_RDCS) && (col_cyc >= C_CAA) &&
                                     (ras_lvl >= C_RAC)));

  always_comb begin
    state_nxt  = state;
    ras_nxt    = ras_n;
    cas_nxt    = cas_n;
    rd_capture = 1'b0;
    case (state)
      ST_IDLE:   if (req_fire) state_nxt = ST_PRECH;
      ST_PRECH:  if (act_ok) begin
                   ras_nxt   = 1'b0;
                   state_nxt = ST_ACT;
                 end
      ST_ACT:    if (ras_lvl >= C_RAH) state_nxt = ST_COLSET;
      ST_COLSET: if (cas_ok) begin
                   cas_nxt   = 1'b0;
                   state_nxt = ST_CAS;
                 end
      ST_CAS:    if (xfer_done) begin
                   cas_nxt    = 1'b1;
                   state_nxt  = ST_CASPRE;
                   rd_capture = !pend_write;
                 end
      ST_CASPRE: state_nxt = ST_OPEN;
      ST_OPEN:   if (ref_grant || open_expired) state_nxt = ST_CLOSE;
                 else if (req_fire) state_nxt = row_hit ? ST_COLSET : ST_CLOSE;
      ST_CLOSE:  if (ras_lvl >= C_RAS) begin
                   ras_nxt   = 1'b1;
                   state_nxt = pend_valid ? ST_PRECH : ST_IDLE;
                 end
      default:   state_nxt = ST_IDLE;
    endcase
  end

  assign ras_fall_evt = ras_n & ~ras_nxt;
  assign ras_rise_evt = ~ras_n & ras_nxt;
  assign cas_fall_evt = cas_n & ~cas_nxt;
  assign cas_rise_evt = ~cas_n & cas_nxt;
  assign enter_prech  = (state_nxt == ST_PRECH) && (state != ST_PRECH);
  assign enter_colset = (state_nxt == ST_COLSET) && (state != ST_COLSET);

  assign dram_ras_n = ras_n;
  assign dram_cas_n = cas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pend_valid  <= 1'b0;
      pend_write  <= 1'b0;
      pend_addr   <= '0;
      pend_wdata  <= '0;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      state     <= state_nxt;
      rsp_valid <= rd_capture;
      if (rd_capture) rsp_rdata <= dram_dq_in;
      if (req_fire) begin
        pend_valid <= 1'b1;
        pend_write <= req_write;
        pend_addr  <= req_addr;
        pend_wdata <= req_wdata;
      end else if (state == ST_CAS && xfer_done) begin
        pend_valid <= 1'b0;
      end
      if (enter_colset) begin
        dram_we_n   <= !src_write;
        dram_dq_out <= src_wdata;
        dram_dq_oe  <= src_write;
      end
      if (cas_fall_evt && !pend_write) dram_oe_n <= 1'b0;
      if (cas_rise_evt) begin
        dram_we_n  <= 1'b1;
        dram_oe_n  <= 1'b1;
        dram_dq_oe <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  p_ras_low_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rise_evt |-> ras_lvl >= C_RAS);
  p_ras_prech_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall_evt |-> (ras_lvl >= C_RP && ras_fall >= C_RC));
  p_cas_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fall_evt |-> (cas_lvl >= C_CP && cas_fall >= C_PC && !ras_n));
  p_cas_in_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  p_read_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!dram_oe_n && !cas_n && ras_lvl >= C_RAC && col_cyc >= C_CAA));
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_write_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall_evt && !dram_we_n) |-> dram_dq_oe);
  p_we_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_we_n));
  p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && ras_n) |=> ras_n);
  p_ref_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> !req_ready);
  p_one_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  p_col_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cas_rise_evt |-> (cas_lvl >= C_CAS && ras_lvl >= C_AR));

endmodule

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_grant = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [8:0]  dram_addr;
  logic [7:0]  dram_dq_out, dram_dq_in;

  always #4 clk = ~clk;   // 125 MHz

  fpm_dram_ctrl #(.MAX_OPEN_NS(800)) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_grant(ref_grant),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  // Cycle counts restated by counting 8 ns steps.
  function automatic int cyc(input int ns);
    int c = 0;
    while (c * 8 < ns) c++;
    return c;
  endfunction
  localparam int E_RAS = 8, E_RP = 7, E_RC = 15, E_PC = 5, E_CP = 2, E_CAS = 2;
  localparam int E_AR = 6, E_RAC = 8, E_CAA = 4, E_CAC = 2;
  int e_open;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  int  m_ras_len, m_cas_len, m_act_len, m_pc_len, m_col_len, ras_falls;
  logic m_ras_prev, m_cas_prev, m_we_prev, m_we_fall;
  logic [8:0] m_row, m_col, m_addr_prev;
  logic m_drive;
  logic [7:0] m_rd;
  assign dram_dq_in = m_drive ? m_rd : 8'hEE;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ras_len = 100; m_cas_len = 100; m_act_len = 100; m_pc_len = 100;
      m_col_len = 0; ras_falls = 0;
      m_ras_prev = 1; m_cas_prev = 1; m_we_prev = 1; m_we_fall = 1;
      m_row = '0; m_col = '0; m_addr_prev = '0; m_drive = 0; m_rd = 8'hEE;
    end else begin
      m_act_len++; m_pc_len++;
      if (dram_addr == m_addr_prev) m_col_len++; else m_col_len = 1;
      // column strobe first: compares use counts through the previous cycle
      if (dram_cas_n != m_cas_prev) begin
        if (!dram_cas_n) begin
          chk(m_cas_len >= E_CP, "R4", "CAS precharge cycles", m_cas_len, E_CP);
          chk(m_pc_len - 1 >= E_PC, "R4", "CAS fall-to-fall", m_pc_len - 1, E_PC);
          chk(!dram_ras_n, "R4", "CAS fall with RAS low", dram_ras_n, 0);
          m_col = dram_addr; m_we_fall = dram_we_n; m_pc_len = 1;
          if (!dram_we_n) begin
            chk(!m_we_prev && dram_dq_oe, "R6", "write strobe and data before CAS",
                {m_we_prev, dram_dq_oe}, 1);
            mem[{m_row, dram_addr}] = dram_dq_out;
          end
        end else begin
          chk(m_cas_len >= E_CAS, "R4", "CAS low cycles", m_cas_len, E_CAS);
          chk(m_ras_len >= E_AR, "R11", "RAS low at CAS rise", m_ras_len, E_AR);
        end
        m_cas_len = 1;
      end else begin
        m_cas_len++;
        if (!dram_cas_n && dram_we_n != m_we_fall)
          chk(0, "R6", "WE moved while CAS low", dram_we_n, m_we_fall);
      end
      if (dram_ras_n != m_ras_prev) begin
        if (dram_ras_n) chk(m_ras_len >= E_RAS, "R3", "RAS low cycles", m_ras_len, E_RAS);
        else begin
          chk(m_ras_len >= E_RP, "R3", "RAS precharge cycles", m_ras_len, E_RP);
          chk(m_act_len - 1 >= E_RC, "R3", "RAS fall-to-fall", m_act_len - 1, E_RC);
          m_row = dram_addr; m_act_len = 1; ras_falls++;
        end
        m_ras_len = 1;
      end else m_ras_len++;
      m_ras_prev = dram_ras_n; m_cas_prev = dram_cas_n; m_we_prev = dram_we_n;
      m_addr_prev = dram_addr;
      m_drive = !dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n &&
                m_ras_len >= E_RAC && m_cas_len >= E_CAC && m_col_len >= E_CAA;
      m_rd = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 8'h00;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q [$];
  logic prev_rsp = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        chk(!prev_rsp, "R5", "rsp_valid single cycle", prev_rsp, 0);
        if (exp_q.size() == 0) chk(0, "R5", "unexpected response", rsp_rdata, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R5", "read data", rsp_rdata, e);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[a] = d;
    else exp_q.push_back(shadow[a]);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10", "ready after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
    if (wr) begin
      chk(m_row == a[17:9], "R2", "row on bus", m_row, a[17:9]);
      chk(m_col == a[8:0], "R2", "column on bus", m_col, a[8:0]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int rf;
    e_open = cyc(800);
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes high",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!dram_dq_oe && !rsp_valid, "R1", "dq_oe/rsp_valid low", {dram_dq_oe, rsp_valid}, 0);
    chk(req_ready, "R1", "ready out of reset", req_ready, 1);
    chk(cyc(60) == E_RAS && cyc(120) == E_RC, "R3", "bench cycle table", cyc(60), E_RAS);

    // open a row, then page hits
    do_req(1, {9'h012, 9'h034}, 8'h5A);
    chk(!dram_ras_n, "R4", "row held open", dram_ras_n, 0);
    rf = ras_falls;
    do_req(1, {9'h012, 9'h1FF}, 8'hA5);
    do_req(0, {9'h012, 9'h034}, 8'h00);
    do_req(0, {9'h012, 9'h1FF}, 8'h00);
    chk(ras_falls == rf, "R4", "no RAS cycle on hits", ras_falls, rf);

    // row miss
    rf = ras_falls;
    do_req(1, {9'h155, 9'h0AA}, 8'h3C);
    chk(ras_falls == rf + 1, "R7", "one RAS cycle on miss", ras_falls, rf + 1);
    rf = ras_falls;
    do_req(0, {9'h012, 9'h034}, 8'h00);
    chk(ras_falls == rf + 1, "R7", "reopen old row", ras_falls, rf + 1);

    // corner addresses
    do_req(1, {9'h1FF, 9'h1FF}, 8'h81);
    do_req(1, 18'h0, 8'h42);
    do_req(0, {9'h1FF, 9'h1FF}, 8'h00);
    do_req(0, 18'h0, 8'h00);
    do_req(0, {9'h155, 9'h0AA}, 8'h00);

    // page burst with interleaved reads
    for (int i = 0; i < 6; i++) do_req(1, {9'h0C3, 9'(i * 37)}, 8'(8'h11 * (i + 1)));
    for (int i = 5; i >= 0; i--) do_req(0, {9'h0C3, 9'(i * 37)}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      do_req(1, {9'(i + 1), 9'h0F0}, 8'(8'h20 + i));
      do_req(0, {9'(i + 1), 9'h0F0}, 8'h00);
    end

    // open-row limit
    do_req(0, {9'h012, 9'h1FF}, 8'h00);
    chk(!dram_ras_n, "R9", "row open after access", dram_ras_n, 0);
    idle(e_open + 20);
    chk(dram_ras_n, "R9", "row closed after limit", dram_ras_n, 1);

    // refresh grant over an open row
    do_req(1, {9'h077, 9'h011}, 8'h99);
    ref_grant = 1;
    req_valid = 1; req_write = 0; req_addr = {9'h077, 9'h011};
    idle(2);
    chk(!req_ready, "R8", "ready low under grant", req_ready, 0);
    idle(15);
    chk(dram_ras_n && dram_cas_n, "R8", "strobes high under grant", {dram_ras_n, dram_cas_n}, 3);
    rf = ras_falls;
    idle(30);
    chk(ras_falls == rf, "R8", "no RAS fall under grant", ras_falls, rf);
    chk(exp_q.size() == 0, "R8", "request held off", exp_q.size(), 0);
    req_valid = 0;
    ref_grant = 0;
    do_req(0, {9'h077, 9'h011}, 8'h00);
    do_req(0, {9'h0C3, 9'h000}, 8'h00);

    idle(10);
    chk(exp_q.size() == 0, "R5", "all reads answered", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule